// File: doc/BRIEF.md
# Frequency Reprogramming Watchdog with Safe-Setting Fallback

This block guards a clock synthesizer while its output frequency is being reprogrammed. Software arms it by writing 1 to its enable bit. The block then counts down a programmed depth, one step per timebase tick, where one tick is nominally 250 ms. The default depth of 8 gives a 2.0 s window. If software has not re-armed the watchdog before the count runs out, the new setting is treated as failed and the block forces the frequency control back to a setting known to work.

On expiry the block raises its timeout flag. It issues a one-cycle strobe that clears the programmable-divider mode bit, so the frequency is again taken from the selection table. In the same cycle it issues a one-cycle load strobe that carries a frequency select code. That code is either a stored safe code or the strap value latched at power-on. The safe-frequency select enable decides which. The safe code register sits outside this block and resets to 00010.

The block also supplies the read-back values for its register fields. While counting, the depth field reads back as the live count. The enable bit reads back as 1 only while a countdown is in progress. The 250 ms timebase itself is produced elsewhere and arrives here as a one-cycle tick.

Top module: `wdt_freq_fallback`

## Requirements
- R1: After synchronous reset, `en_rb_o`, `timeout_o`, `fsel_load_o` and `mn_clear_o` are 0, and `fsel_o` is 0.
- R2: A cycle with `en_wr_i`=1 and `en_wr_val_i`=1 starts a countdown. From the next cycle, `en_rb_o` is 1, `count_o` equals the depth sampled with the write, and `timeout_o` is 0.
- R3: While counting, each cycle with `tick_i`=1 lowers `count_o` by exactly one. Cycles without a tick leave `count_o` unchanged.
- R4: While no countdown is in progress, `count_o` shows `depth_i`.
- R5: With depth D of 1 or more, expiry happens on the D-th tick after the start. With depth 0, expiry happens on the first tick.
- R6: In the cycle after the expiring tick, `timeout_o` is 1, `en_rb_o` is 0, and `fsel_load_o` and `mn_clear_o` are both 1 for exactly that one cycle.
- R7: With the load strobe, `fsel_o` equals `safe_code_i` if `safe_sel_i` was 1 in the expiring cycle, and `strap_code_i` otherwise. `fsel_o` then holds that value.
- R8: Each expiry produces the strobes once. Further ticks after expiry produce no strobe until the watchdog is started again.
- R9: A cycle with `en_wr_i`=1 and `en_wr_val_i`=0 stops the countdown. It does not set the timeout flag, issues no strobe, and leaves `timeout_o` at its previous value.
- R10: A start write wins over a tick in the same cycle, even on the last count. It reloads the depth and clears `timeout_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| en_wr_i | input | 1 | One-cycle pulse: the enable bit is being written |
| en_wr_val_i | input | 1 | Value written to the enable bit |
| depth_i | input | DEPTH_W | Countdown depth in timebase ticks |
| safe_sel_i | input | 1 | 1: fall back to the safe code; 0: fall back to the strap value |
| safe_code_i | input | CODE_W | Stored safe frequency code |
| strap_code_i | input | CODE_W | Frequency code latched from the straps at power-on |
| tick_i | input | 1 | One-cycle timebase tick (nominally every 250 ms) |
| count_o | output | DEPTH_W | Depth read-back: the live count while running, otherwise the depth |
| timeout_o | output | 1 | Set by expiry, cleared by a start write |
| en_rb_o | output | 1 | Enable read-back, 1 while a countdown is in progress |
| fsel_o | output | CODE_W | Fallback frequency select code |
| fsel_load_o | output | 1 | One-cycle strobe to load `fsel_o` into the frequency select |
| mn_clear_o | output | 1 | One-cycle strobe to clear the programmable-divider mode bit |

## Verification
The hardest case to reach is a start write that lands in the very cycle of the expiring tick. The count must already sit on its last step when the write arrives, and the write has to suppress both strobes. The bench runs a countdown to its final step and then drives the write and the tick on the same falling edge. Depth sweeps from 0 to 12 and a run at the maximum depth of 127 reach the boundary counts, each with both fallback sources, and they count exactly how many ticks pass before the strobes.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int unsigned WD_DEPTH_W = 7;
    localparam int unsigned WD_CODE_W  = 5;

    typedef enum logic {
        WD_IDLE = 1'b0,
        WD_RUN  = 1'b1
    } wd_state_e;

    typedef struct packed {
        logic load;
        logic clr_mn;
    } wd_strobe_t;

    function automatic wd_strobe_t wd_strobe_from(input logic fire);
        wd_strobe_t s;
        s.load   = fire;
        s.clr_mn = fire;
        return s;
    endfunction

endpackage

// File: rtl/wdt_counter.sv
module wdt_counter
    import wdt_pkg::*;
#(
    parameter int unsigned DW = WD_DEPTH_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          stop,
    input  logic          tick,
    input  logic [DW-1:0] depth,
    output logic          running,
    output logic [DW-1:0] cnt,
    output logic          timeout,
    output logic          expire
);

    wd_state_e     state_q;
    logic [DW-1:0] cnt_q;
    logic          to_q;
    logic          last_step;

    // zero or one remaining: this tick ends the countdown
    assign last_step = (cnt_q[DW-1:1] == '0);
    assign expire    = (state_q == WD_RUN) && tick && !start && !stop && last_step;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= WD_IDLE;
            cnt_q   <= '0;
            to_q    <= 1'b0;
        end else if (start) begin
            state_q <= WD_RUN;
            cnt_q   <= depth;
            to_q    <= 1'b0;
        end else if (stop) begin
            state_q <= WD_IDLE;
        end else if (state_q == WD_RUN && tick) begin
            if (last_step) begin
                state_q <= WD_IDLE;
                cnt_q   <= '0;
                to_q    <= 1'b1;
            end else begin
                cnt_q <= cnt_q - DW'(1);
            end
        end
    end

    assign running = (state_q == WD_RUN);
    assign cnt     = cnt_q;
    assign timeout = to_q;

endmodule

// File: rtl/wdt_action.sv
module wdt_action
    import wdt_pkg::*;
#(
    parameter int unsigned CW = WD_CODE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          expire,
    input  logic          safe_sel,
    input  logic [CW-1:0] safe_code,
    input  logic [CW-1:0] strap_code,
    output wd_strobe_t    strobe,
    output logic [CW-1:0] code
);

    wd_strobe_t    strobe_q;
    logic [CW-1:0] code_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            strobe_q <= '0;
            code_q   <= '0;
        end else begin
            strobe_q <= wd_strobe_from(expire);
            if (expire) begin
                code_q <= safe_sel ? safe_code : strap_code;
            end
        end
    end

    assign strobe = strobe_q;
    assign code   = code_q;

endmodule

// File: rtl/wdt_freq_fallback.sv
module wdt_freq_fallback
    import wdt_pkg::*;
#(
    parameter int unsigned DEPTH_W = WD_DEPTH_W,
    parameter int unsigned CODE_W  = WD_CODE_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               en_wr_i,
    input  logic               en_wr_val_i,
    input  logic [DEPTH_W-1:0] depth_i,
    input  logic               safe_sel_i,
    input  logic [CODE_W-1:0]  safe_code_i,
    input  logic [CODE_W-1:0]  strap_code_i,
    input  logic               tick_i,
    output logic [DEPTH_W-1:0] count_o,
    output logic               timeout_o,
    output logic               en_rb_o,
    output logic [CODE_W-1:0]  fsel_o,
    output logic               fsel_load_o,
    output logic               mn_clear_o
);

    logic               running;
    logic [DEPTH_W-1:0] cnt;
    logic               expire;
    wd_strobe_t         strobe;

    wdt_counter #(.DW(DEPTH_W)) u_counter (
        .clk     (clk),
        .rst     (rst),
        .start   (en_wr_i && en_wr_val_i),
        .stop    (en_wr_i && !en_wr_val_i),
        .tick    (tick_i),
        .depth   (depth_i),
        .running (running),
        .cnt     (cnt),
        .timeout (timeout_o),
        .expire  (expire)
    );

    wdt_action #(.CW(CODE_W)) u_action (
        .clk        (clk),
        .rst        (rst),
        .expire     (expire),
        .safe_sel   (safe_sel_i),
        .safe_code  (safe_code_i),
        .strap_code (strap_code_i),
        .strobe     (strobe),
        .code       (fsel_o)
    );

    assign count_o     = running ? cnt : depth_i;
    assign en_rb_o     = running;
    assign fsel_load_o = strobe.load;
    assign mn_clear_o  = strobe.clr_mn;

endmodule

// File: rtl/wdt_fallback_chk.sv
module wdt_fallback_chk #(
    parameter int unsigned DW = 7,
    parameter int unsigned CW = 5
) (
    input logic          clk,
    input logic          rst,
    input logic          en_wr_i,
    input logic          en_wr_val_i,
    input logic [DW-1:0] depth_i,
    input logic          safe_sel_i,
    input logic [CW-1:0] safe_code_i,
    input logic [CW-1:0] strap_code_i,
    input logic          tick_i,
    input logic [DW-1:0] count_o,
    input logic          timeout_o,
    input logic          en_rb_o,
    input logic [CW-1:0] fsel_o,
    input logic          fsel_load_o,
    input logic          mn_clear_o
);

    p_start_arms_r2: assert property (@(posedge clk) disable iff (rst)
        (en_wr_i && en_wr_val_i) |=> (en_rb_o && !timeout_o && count_o == $past(depth_i)));

    p_hold_no_tick_r3: assert property (@(posedge clk) disable iff (rst)
        (en_rb_o && !tick_i && !en_wr_i) |=> (en_rb_o && count_o == $past(count_o)));

    p_strobe_flag_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(timeout_o) |-> (fsel_load_o && mn_clear_o && !en_rb_o));

    p_strobe_once_r8: assert property (@(posedge clk) disable iff (rst)
        fsel_load_o |=> !fsel_load_o && !mn_clear_o);

    p_fsel_source_r7: assert property (@(posedge clk) disable iff (rst)
        fsel_load_o |-> fsel_o == ($past(safe_sel_i) ? $past(safe_code_i) : $past(strap_code_i)));

    p_stop_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        (en_wr_i && !en_wr_val_i) |=> (!fsel_load_o && !en_rb_o && timeout_o == $past(timeout_o)));

    p_start_wins_r10: assert property (@(posedge clk) disable iff (rst)
        (en_wr_i && en_wr_val_i && tick_i) |=> !fsel_load_o);

endmodule

bind wdt_freq_fallback wdt_fallback_chk #(.DW(DEPTH_W), .CW(CODE_W)) i_chk (.*);

// File: tb/test_wdt_freq_fallback.sv
module test_wdt_freq_fallback;

    localparam int DW = 7;
    localparam int CW = 5;

    logic          clk = 1'b0;
    logic          rst;
    logic          en_wr_i, en_wr_val_i, safe_sel_i, tick_i;
    logic [DW-1:0] depth_i;
    logic [CW-1:0] safe_code_i, strap_code_i;
    logic [DW-1:0] count_o;
    logic          timeout_o, en_rb_o, fsel_load_o, mn_clear_o;
    logic [CW-1:0] fsel_o;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    wdt_freq_fallback i_wdt_freq_fallback (
        .clk(clk), .rst(rst), .en_wr_i(en_wr_i), .en_wr_val_i(en_wr_val_i),
        .depth_i(depth_i), .safe_sel_i(safe_sel_i), .safe_code_i(safe_code_i),
        .strap_code_i(strap_code_i), .tick_i(tick_i), .count_o(count_o),
        .timeout_o(timeout_o), .en_rb_o(en_rb_o), .fsel_o(fsel_o),
        .fsel_load_o(fsel_load_o), .mn_clear_o(mn_clear_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    task automatic start_wd(input int d);
        @(negedge clk);
        depth_i = DW'(d); en_wr_i = 1'b1; en_wr_val_i = 1'b1;
        @(negedge clk);
        en_wr_i = 1'b0;
    endtask

    task automatic do_tick();
        tick_i = 1'b1;
        @(negedge clk);
        tick_i = 1'b0;
    endtask

    task automatic run_case(input int d, input bit s);
        int n;
        logic [CW-1:0] sc, st;
        sc = CW'(d) ^ 5'h15;
        st = CW'(d) ^ 5'h0A;
        safe_sel_i = s; safe_code_i = sc; strap_code_i = st;
        start_wd(d);
        chk("R2 en_rb after start", en_rb_o, 1);
        chk("R2 count after start", count_o, d);
        chk("R10 start clears timeout", timeout_o, 0);
        n = (d == 0) ? 1 : d;
        for (int k = 1; k <= n; k++) begin
            do_tick();
            if (k < n) begin
                chk("R3 count per tick", count_o, d - k);
                chk("R5 no early expiry", fsel_load_o, 0);
            end else begin
                chk("R5 expiry on last tick", timeout_o, 1);
                chk("R6 en_rb low after expiry", en_rb_o, 0);
                chk("R6 load strobe", fsel_load_o, 1);
                chk("R6 clear strobe", mn_clear_o, 1);
                chk("R7 fallback code", fsel_o, s ? sc : st);
            end
        end
        @(negedge clk);
        chk("R6 load strobe one cycle", fsel_load_o, 0);
        chk("R6 clear strobe one cycle", mn_clear_o, 0);
        do_tick();
        chk("R8 no strobe on later tick", fsel_load_o, 0);
        chk("R8 timeout stays", timeout_o, 1);
        chk("R4 idle count shows depth", count_o, d);
        chk("R7 code held", fsel_o, s ? sc : st);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        rst = 1'b1; en_wr_i = 0; en_wr_val_i = 0; tick_i = 0; depth_i = 7'd8;
        safe_sel_i = 0; safe_code_i = 5'b00010; strap_code_i = 5'd9;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 en_rb", en_rb_o, 0);
        chk("R1 timeout", timeout_o, 0);
        chk("R1 load strobe", fsel_load_o, 0);
        chk("R1 clear strobe", mn_clear_o, 0);
        chk("R1 fsel", fsel_o, 0);
        chk("R4 count shows depth", count_o, 8);

        for (int d = 0; d <= 12; d++) begin
            for (int s = 0; s < 2; s++) run_case(d, s[0]);
        end
        run_case(127, 1'b1);
        run_case(127, 1'b0);

        // R3 hold without ticks
        start_wd(6);
        repeat (4) @(negedge clk);
        chk("R3 hold without tick", count_o, 6);
        do_tick();
        do_tick();
        chk("R3 two ticks", count_o, 4);

        // R9 stop write
        @(negedge clk);
        en_wr_i = 1'b1; en_wr_val_i = 1'b0; depth_i = 7'd6;
        @(negedge clk);
        en_wr_i = 1'b0;
        chk("R9 en_rb low after stop", en_rb_o, 0);
        chk("R9 no timeout on stop", timeout_o, 0);
        chk("R9 no strobe on stop", fsel_load_o, 0);
        for (int k = 0; k < 8; k++) begin
            do_tick();
            chk("R9 ticks after stop no strobe", fsel_load_o, 0);
        end
        chk("R9 timeout still clear", timeout_o, 0);

        // R9 stop keeps a set timeout flag
        start_wd(1);
        do_tick();
        chk("R5 depth 1 expiry", timeout_o, 1);
        @(negedge clk);
        en_wr_i = 1'b1; en_wr_val_i = 1'b0;
        @(negedge clk);
        en_wr_i = 1'b0;
        chk("R9 timeout kept by stop", timeout_o, 1);

        // R10 start coincides with the expiring tick
        start_wd(2);
        do_tick();
        chk("R10 at last step", count_o, 1);
        depth_i = 7'd3; en_wr_i = 1'b1; en_wr_val_i = 1'b1; tick_i = 1'b1;
        @(negedge clk);
        en_wr_i = 1'b0; tick_i = 1'b0;
        chk("R10 no timeout", timeout_o, 0);
        chk("R10 reloaded", count_o, 3);
        chk("R10 still running", en_rb_o, 1);
        @(negedge clk);
        chk("R10 no strobe", fsel_load_o, 0);

        finish_run();
    end

endmodule